// File: doc/BRIEF.md
# Dirty-Tracked Register Context Save/Restore

This block holds a bank of eight optional 48-bit registers and moves them to or from a context area in memory when the operating system switches between processes. Each register carries a dirty bit that is set only while the register holds a nonzero value. Both directions run on every switch. Nothing is deferred until the registers are first used, so no stale register contents from one process can reach the next.

A save writes one flag word that lists the dirty registers, then writes only those registers, packed one after another. A restore reads the flag word, loads only the registers it marks, and forces every other register to zero. The memory port moves one 16-bit word per cycle. A register is three words, least significant word first, so a switch costs one cycle for the flag word plus three cycles per dirty register. A full bank therefore takes 25 cycles. Memory read data must be valid in the same cycle as the read request.

Between switches the core reads and writes the bank through its own port. The sequencer owns the bank while an operation runs.

Top module: `ctx_swap_seq`

## Requirements
- R1: After reset `busy`, `done`, `memWrEn` and `memRdEn` are low, every bank register reads zero and `coreDirty` is zero.
- R2: After any write to register i, whether from the core port or from a restore, `coreDirty[i]` is 1 exactly when the register holds a nonzero value. Writing zero clears it.
- R3: In the cycle after a save is accepted (`start` high, `opRestore` low, block idle), the block writes a flag word to `ctxBase`. Bit i (i = 0..7) of that word is register i's dirty bit as it stood in the start cycle, and bits 15:8 are zero.
- R4: After the flag word, a save writes only the dirty registers, in ascending index order. Each register goes out as three words: bits 15:0, then 31:16, then 47:32. The words go to consecutive addresses from `ctxBase`+1 with no gap left for clean registers.
- R5: In the cycle after a restore is accepted (`opRestore` high), the block reads the flag word at `ctxBase` and ignores its bits 15:8. Every register whose flag bit (bit i for register i) is 0 reads zero afterwards, with its dirty bit clear.
- R6: For each flag bit that is set, in ascending index order, a restore reads three consecutive words starting at `ctxBase`+1. The register then holds {third, second, first}.
- R7: Transfers fill exactly 1 + 3n consecutive cycles, beginning in the cycle after the accepted start. n is the number of dirty registers for a save and the number of set flag bits for a restore. `done` is high for exactly one cycle, directly after the last transfer. `busy` is high from the first transfer through the `done` cycle.
- R8: A `start` seen while `busy` is high is ignored. A core write is dropped if `busy` is high or `start` is high in the same cycle.
- R9: `memWrEn` and `memRdEn` are never high together, and neither is high while `busy` is low. A save uses only writes and a restore uses only reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Command strobe, accepted only when idle |
| opRestore | input | 1 | Operation select: 0 save, 1 restore |
| ctxBase | input | ADDR_W | Word address of the context area |
| busy | output | 1 | Operation in progress, including the done cycle |
| done | output | 1 | One-cycle completion pulse |
| memAddr | output | ADDR_W | Word address of the current transfer |
| memWrEn | output | 1 | Memory write strobe |
| memWrData | output | 16 | Memory write data |
| memRdEn | output | 1 | Memory read strobe |
| memRdData | input | 16 | Memory read data, valid in the request cycle |
| coreWrEn | input | 1 | Core write to the bank |
| coreWrIdx | input | 3 | Core write register index |
| coreWrData | input | 48 | Core write value |
| coreRdIdx | input | 3 | Core read register index |
| coreRdData | output | 48 | Core read value (combinational) |
| coreDirty | output | 8 | Dirty bit of each register |

## Verification
Two pairs of events can fall in the same cycle. The first is a core write in the cycle that a save command is accepted. The second is a restart command or a core write during a running operation, including its done cycle. The bench provokes both: it drives the write together with `start`, then holds `start` (with a restore selected) and a core write high through a whole save. The per-cycle model expects the flag word and data to reflect the bank as it stood before the start cycle and expects no second operation to begin. Readback of the targeted clean registers, which must stay zero and clean, shows whether the dropped writes leaked into the bank.

// File: rtl/ctx_swap_pkg.sv
package ctx_swap_pkg;
  localparam int CTX_REGS   = 8;
  localparam int CTX_REG_W  = 48;
  localparam int CTX_MEM_W  = 16;
  localparam int CTX_WORDS  = CTX_REG_W / CTX_MEM_W;
  localparam int CTX_HOLD_W = CTX_REG_W - CTX_MEM_W;
  localparam int CTX_IDX_W  = $clog2(CTX_REGS);
  localparam int CTX_SEL_W  = $clog2(CTX_WORDS);

  typedef enum logic [1:0] {
    S_IDLE,
    S_FLAG,
    S_XFER,
    S_FIN
  } ctx_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                 emitFlag;  // drive the flag word on the write bus
    logic                 clrClean;  // zero registers whose flag bit is clear
    logic                 capWord;   // capture a restore word
    logic [CTX_SEL_W-1:0] wordSel;   // word within current register
  } ctx_strobe_t;
endpackage

// File: rtl/ctx_swap_ctrl.sv
module ctx_swap_ctrl
  import ctx_swap_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic                 opRestore,
  input  logic [ADDR_W-1:0]    ctxBase,
  input  logic [CTX_REGS-1:0]  dirtyVec,
  input  logic [CTX_REGS-1:0]  flagIn,
  output ctx_strobe_t          st,
  output logic [CTX_IDX_W-1:0] curIdx,
  output logic [CTX_REGS-1:0]  pendMask,
  output logic [ADDR_W-1:0]    memAddr,
  output logic                 memWrEn,
  output logic                 memRdEn,
  output logic                 busy,
  output logic                 done
);
  ctx_state_e           state;
  logic                 isRestore;
  logic [ADDR_W-1:0]    ptr;
  logic [CTX_REGS-1:0]  pend;
  logic [CTX_SEL_W-1:0] wordSel;
  logic [CTX_REGS-1:0]  pendAfter;
  logic [CTX_REGS-1:0]  maskAtFlag;
  logic                 lastWord;
  logic                 xferCycle;

  // lowest pending register index
  always_comb begin
    curIdx = '0;
    for (int i = CTX_REGS - 1; i >= 0; i--) begin
      if (pend[i]) curIdx = CTX_IDX_W'(i);
    end
  end

  always_comb begin
    pendAfter  = pend & ~(CTX_REGS'(1) << curIdx);
    maskAtFlag = isRestore ? flagIn : pend;
    lastWord   = (wordSel == CTX_SEL_W'(CTX_WORDS - 1));
    xferCycle  = (state == S_FLAG) || (state == S_XFER);
    memWrEn    = xferCycle && !isRestore;
    memRdEn    = xferCycle && isRestore;
    memAddr    = ptr;
    busy       = (state != S_IDLE);
    done       = (state == S_FIN);
    pendMask   = pend;
    st.emitFlag = (state == S_FLAG);
    st.clrClean = (state == S_FLAG) && isRestore;
    st.capWord  = (state == S_XFER) && isRestore;
    st.wordSel  = wordSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      isRestore <= 1'b0;
      ptr       <= '0;
      pend      <= '0;
      wordSel   <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) begin
            state     <= S_FLAG;
            isRestore <= opRestore;
            ptr       <= ctxBase;
            pend      <= dirtyVec;
            wordSel   <= '0;
          end
        end
        S_FLAG: begin
          ptr   <= ptr + ADDR_W'(1);
          pend  <= maskAtFlag;
          state <= (maskAtFlag != '0) ? S_XFER : S_FIN;
        end
        S_XFER: begin
          ptr <= ptr + ADDR_W'(1);
          if (lastWord) begin
            wordSel <= '0;
            pend    <= pendAfter;
            state   <= (pendAfter == '0) ? S_FIN : S_XFER;
          end else begin
            wordSel <= wordSel + CTX_SEL_W'(1);
          end
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ctx_reg_bank.sv
module ctx_reg_bank
  import ctx_swap_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctx_strobe_t          st,
  input  logic [CTX_IDX_W-1:0] curIdx,
  input  logic [CTX_REGS-1:0]  pendMask,
  input  logic [CTX_MEM_W-1:0] memRdData,
  input  logic                 coreWe,
  input  logic [CTX_IDX_W-1:0] coreWrIdx,
  input  logic [CTX_REG_W-1:0] coreWrData,
  input  logic [CTX_IDX_W-1:0] coreRdIdx,
  output logic [CTX_REG_W-1:0] coreRdData,
  output logic [CTX_REGS-1:0]  dirtyVec,
  output logic [CTX_MEM_W-1:0] memWrData
);
  logic [CTX_REG_W-1:0]  bank [CTX_REGS];
  logic [CTX_HOLD_W-1:0] hold;
  logic [CTX_REG_W-1:0]  restoreVal;
  logic [CTX_REG_W-1:0]  saveReg;
  logic [CTX_MEM_W-1:0]  saveWord;
  logic                  writeBack;

  always_comb begin
    restoreVal = {memRdData, hold};
    writeBack  = st.capWord && (st.wordSel == CTX_SEL_W'(CTX_WORDS - 1));
    saveReg    = bank[curIdx];
    saveWord   = '0;
    for (int w = 0; w < CTX_WORDS; w++) begin
      if (st.wordSel == CTX_SEL_W'(w)) saveWord = saveReg[w*CTX_MEM_W +: CTX_MEM_W];
    end
    memWrData  = st.emitFlag ? CTX_MEM_W'(pendMask) : saveWord;
    coreRdData = bank[coreRdIdx];
  end

  // assemble lower words of a restored register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hold <= '0;
    end else if (st.capWord) begin
      for (int w = 0; w < CTX_WORDS - 1; w++) begin
        if (st.wordSel == CTX_SEL_W'(w)) hold[w*CTX_MEM_W +: CTX_MEM_W] <= memRdData;
      end
    end
  end

  for (genvar g = 0; g < CTX_REGS; g++) begin : gReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bank[g]     <= '0;
        dirtyVec[g] <= 1'b0;
      end else if (st.clrClean && !memRdData[g]) begin
        bank[g]     <= '0;
        dirtyVec[g] <= 1'b0;
      end else if (writeBack && (curIdx == CTX_IDX_W'(g))) begin
        bank[g]     <= restoreVal;
        dirtyVec[g] <= (restoreVal != '0);
      end else if (coreWe && (coreWrIdx == CTX_IDX_W'(g))) begin
        bank[g]     <= coreWrData;
        dirtyVec[g] <= (coreWrData != '0);
      end
    end
  end
endmodule

// File: rtl/ctx_swap_seq.sv
module ctx_swap_seq
  import ctx_swap_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic                 opRestore,
  input  logic [ADDR_W-1:0]    ctxBase,
  output logic                 busy,
  output logic                 done,
  output logic [ADDR_W-1:0]    memAddr,
  output logic                 memWrEn,
  output logic [CTX_MEM_W-1:0] memWrData,
  output logic                 memRdEn,
  input  logic [CTX_MEM_W-1:0] memRdData,
  input  logic                 coreWrEn,
  input  logic [CTX_IDX_W-1:0] coreWrIdx,
  input  logic [CTX_REG_W-1:0] coreWrData,
  input  logic [CTX_IDX_W-1:0] coreRdIdx,
  output logic [CTX_REG_W-1:0] coreRdData,
  output logic [CTX_REGS-1:0]  coreDirty
);
  ctx_strobe_t          st;
  logic [CTX_IDX_W-1:0] curIdx;
  logic [CTX_REGS-1:0]  pendMask;
  logic                 coreWe;

  assign coreWe = coreWrEn && !busy && !start;

  ctx_swap_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .opRestore (opRestore),
    .ctxBase   (ctxBase),
    .dirtyVec  (coreDirty),
    .flagIn    (memRdData[CTX_REGS-1:0]),
    .st        (st),
    .curIdx    (curIdx),
    .pendMask  (pendMask),
    .memAddr   (memAddr),
    .memWrEn   (memWrEn),
    .memRdEn   (memRdEn),
    .busy      (busy),
    .done      (done)
  );

  ctx_reg_bank uBank (
    .clk        (clk),
    .rstN       (rstN),
    .st         (st),
    .curIdx     (curIdx),
    .pendMask   (pendMask),
    .memRdData  (memRdData),
    .coreWe     (coreWe),
    .coreWrIdx  (coreWrIdx),
    .coreWrData (coreWrData),
    .coreRdIdx  (coreRdIdx),
    .coreRdData (coreRdData),
    .dirtyVec   (coreDirty),
    .memWrData  (memWrData)
  );
endmodule

// File: rtl/ctx_swap_chk.sv
module ctx_swap_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              memWrEn,
  input logic              memRdEn,
  input logic [ADDR_W-1:0] ctxBase,
  input logic [ADDR_W-1:0] memAddr
);
  a_r9_one_direction: assert property (@(posedge clk) disable iff (!rstN)
    !(memWrEn && memRdEn));

  a_r9_quiet_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(memWrEn || memRdEn));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  a_r7_start_takes: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  a_r7_gap_only_done: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !(memWrEn || memRdEn)) |-> done);

  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    ((memWrEn || memRdEn) && $past(memWrEn || memRdEn)) |-> (memAddr == $past(memAddr) + ADDR_W'(1)));

  a_r3_flag_at_base: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ((memWrEn || memRdEn) && (memAddr == $past(ctxBase))));
endmodule

bind ctx_swap_seq ctx_swap_chk #(.ADDR_W(ADDR_W)) uChk (.*);

// File: tb/ctx_swap_seq_test.sv
`timescale 1ns/1ps
module ctx_swap_seq_test;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          opRestore = 1'b0;
  logic [AW-1:0] ctxBase = '0;
  logic          busy, done, memWrEn, memRdEn;
  logic [AW-1:0] memAddr;
  logic [15:0]   memWrData, memRdData;
  logic          coreWrEn = 1'b0;
  logic [2:0]    coreWrIdx = '0;
  logic [47:0]   coreWrData = '0;
  logic [2:0]    coreRdIdx = '0;
  logic [47:0]   coreRdData;
  logic [7:0]    coreDirty;

  logic [15:0] memImg [256];
  logic [47:0] mReg [8];
  int checks = 0;
  int errors = 0;

  typedef struct {
    bit          busy, done, we, re;
    logic [15:0] addr, data;
    string       tag;
  } cyc_t;
  cyc_t expQ[$];

  assign memRdData = memImg[memAddr[7:0]];

  always #2 clk = ~clk;

  ctx_swap_seq #(.ADDR_W(AW)) uut (.*);

  function automatic cyc_t mkCyc(bit b, bit d, bit w, bit r, logic [15:0] a, logic [15:0] dt, string t);
    cyc_t c;
    c.busy = b; c.done = d; c.we = w; c.re = r; c.addr = a; c.data = dt; c.tag = t;
    return c;
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one clock: compare outputs against the model's record for this cycle
  task automatic step();
    cyc_t e;
    @(negedge clk);
    if (expQ.size() > 0) e = expQ.pop_front();
    else e = mkCyc(0, 0, 0, 0, '0, '0, "R7");
    chk(e.tag, "busy", 64'(busy), 64'(e.busy));
    chk(e.tag, "done", 64'(done), 64'(e.done));
    chk("R9", "memWrEn", 64'(memWrEn), 64'(e.we));
    chk("R9", "memRdEn", 64'(memRdEn), 64'(e.re));
    if (e.we || e.re) chk(e.tag, "memAddr", 64'(memAddr), 64'(e.addr));
    if (e.we) chk(e.tag, "memWrData", 64'(memWrData), 64'(e.data));
  endtask

  task automatic coreWrite(input int idx, input logic [47:0] val);
    coreWrEn = 1'b1; coreWrIdx = 3'(idx); coreWrData = val;
    step();
    coreWrEn = 1'b0;
    mReg[idx] = val;
  endtask

  task automatic checkBank(input string tag);
    for (int i = 0; i < 8; i++) begin
      coreRdIdx = 3'(i);
      step();
      chk(tag, $sformatf("reg%0d", i), 64'(coreRdData), 64'(mReg[i]));
      chk("R2", $sformatf("dirty%0d", i), 64'(coreDirty[i]), 64'(mReg[i] != '0));
    end
  endtask

  task automatic runSave(input logic [15:0] base, input bit sameCycleWr, input bit busyPoke);
    logic [7:0]  mask;
    logic [15:0] a;
    for (int i = 0; i < 8; i++) mask[i] = (mReg[i] != '0);
    expQ.push_back(mkCyc(1, 0, 1, 0, base, {8'h00, mask}, "R3"));
    memImg[base[7:0]] = {8'h00, mask};
    a = base + 16'd1;
    for (int i = 0; i < 8; i++) begin
      if (mask[i]) begin
        for (int w = 0; w < 3; w++) begin
          expQ.push_back(mkCyc(1, 0, 1, 0, a, mReg[i][w*16 +: 16], "R4"));
          memImg[a[7:0]] = mReg[i][w*16 +: 16];
          a = a + 16'd1;
        end
      end
    end
    expQ.push_back(mkCyc(1, 1, 0, 0, '0, '0, "R7"));
    start = 1'b1; opRestore = 1'b0; ctxBase = base;
    if (sameCycleWr) begin  // R8: write in the start cycle is dropped
      coreWrEn = 1'b1; coreWrIdx = 3'd5; coreWrData = 48'hDEAD_BEEF_0505;
    end
    step();
    start = 1'b0; coreWrEn = 1'b0;
    if (busyPoke) begin  // R8: restart and core write while busy
      start = 1'b1; opRestore = 1'b1; ctxBase = 16'h00F0;
      coreWrEn = 1'b1; coreWrIdx = 3'd6; coreWrData = 48'h1234_5678_9ABC;
    end
    while (expQ.size() > 0) step();
    start = 1'b0; coreWrEn = 1'b0; opRestore = 1'b0;
    step();
  endtask

  task automatic runRestore(input logic [15:0] base);
    logic [7:0]  mask;
    logic [15:0] a;
    logic [47:0] nxt [8];
    mask = memImg[base[7:0]][7:0];
    expQ.push_back(mkCyc(1, 0, 0, 1, base, '0, "R5"));
    a = base + 16'd1;
    for (int i = 0; i < 8; i++) begin
      nxt[i] = '0;
      if (mask[i]) begin
        for (int w = 0; w < 3; w++) begin
          expQ.push_back(mkCyc(1, 0, 0, 1, a, '0, "R6"));
          nxt[i][w*16 +: 16] = memImg[a[7:0]];
          a = a + 16'd1;
        end
      end
    end
    expQ.push_back(mkCyc(1, 1, 0, 0, '0, '0, "R7"));
    start = 1'b1; opRestore = 1'b1; ctxBase = base;
    step();
    start = 1'b0;
    while (expQ.size() > 0) step();
    opRestore = 1'b0;
    step();
    for (int i = 0; i < 8; i++) mReg[i] = nxt[i];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R7 watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) memImg[i] = '0;
    for (int i = 0; i < 8; i++) mReg[i] = '0;
    repeat (2) @(negedge clk);
    chk("R1", "busy in reset", 64'(busy), 64'd0);
    chk("R1", "done in reset", 64'(done), 64'd0);
    chk("R1", "strobes in reset", 64'(memWrEn | memRdEn), 64'd0);
    rstN = 1'b1;
    checkBank("R1");

    // R2: dirty follows nonzero contents
    coreWrite(1, 48'hA1B2_C3D4_E5F6);
    coreWrite(4, 48'h0000_0000_0001);
    coreWrite(7, 48'h8000_0000_0000);
    coreWrite(2, 48'h5555_5555_5555);
    coreWrite(2, 48'h0);
    checkBank("R2");

    // R3 R4 R7: save of a sparse bank
    runSave(16'h0010, 1'b0, 1'b0);
    // R8: same-cycle write and busy pokes
    runSave(16'h0040, 1'b1, 1'b1);
    checkBank("R8");

    // R5: restore zeroes registers not flagged
    coreWrite(0, 48'h7777_7777_7777);
    coreWrite(3, 48'h0303_0303_0303);
    coreWrite(1, 48'h0000_0000_0001);
    runRestore(16'h0010);
    checkBank("R5");

    // R6: crafted image, junk in flag bits 15:8, zero-valued flagged register
    memImg[8'h80] = 16'hA581;
    memImg[8'h81] = 16'h0000; memImg[8'h82] = 16'h0000; memImg[8'h83] = 16'h0000;
    memImg[8'h84] = 16'h1111; memImg[8'h85] = 16'h2222; memImg[8'h86] = 16'h3333;
    runRestore(16'h0080);
    checkBank("R6");

    // R7: empty restore and empty save
    memImg[8'hA0] = 16'h0000;
    runRestore(16'h00A0);
    checkBank("R5");
    runSave(16'h00B0, 1'b0, 1'b0);

    // R7: full bank, 25 transfer cycles, then round trip
    for (int i = 0; i < 8; i++) coreWrite(i, {16'(i + 1), 16'h00F0 + 16'(i), 16'hABC0 + 16'(i)});
    runSave(16'h00C0, 1'b0, 1'b0);
    runRestore(16'h00A0);
    checkBank("R5");
    runRestore(16'h00C0);
    checkBank("R6");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule